// File: doc/BRIEF.md
# Memory Fill Channel

This block is a single DMA channel that writes one repeating 64-bit word across a contiguous memory region. Software sets a destination address, a length in bytes and two 32-bit pattern halves through a small register port. It then writes a start command. The channel issues 64-bit writes on a valid/ready port, one beat per accepted handshake. It groups the beats into bursts no longer than a programmable limit and returns to idle by itself when the region is covered.

The channel has three states: idle, active and paused. Each command applies only in the states where it is legal. In every other state it is dropped silently, so the status register is the only view of progress. The operation mode sits in the configuration word but has its own write address. Rewriting the burst limits therefore cannot disturb the mode.

Register map (word addresses on `reg_addr`):

| Address | Register | Fields |
|---------|----------|--------|
| 0 | CFG | bits 2:0 read back the mode; bits 11:8 hold the destination burst limit; bits 15:12 hold the source burst limit |
| 1 | MODE | bits 2:0 are written to the mode; the value 2 selects fill mode |
| 2 | DST | destination byte address |
| 3 | SIZE | block length in bytes |
| 4 | PAT_LO | low 32 bits of the fill word |
| 5 | PAT_HI | high 32 bits of the fill word |
| 6 | ACT | write: bit 0 start, bit 1 stop, bit 2 pause, bit 3 restart; read: bits 1:0 give the status (0 idle, 1 active, 2 paused) |

Top module: `memfill_chan`

## Requirements
- R1: After reset, the status reads 0 (idle), both burst limit fields read 4, the mode reads 0 and `wr_valid` is low. The status never reads 3.
- R2: A start accepted from idle makes the status read 1. Writes then begin at the DST address, and the address rises by 8 for each accepted beat. Every beat carries `{PAT_HI, PAT_LO}`.
- R3: The channel issues exactly SIZE/8 beats and then returns to idle. After the final beat it does not raise `wr_valid` again.
- R4: `wr_last` is high on every beat that ends a burst. A burst holds the destination limit in beats (a limit of 0 counts as 1), or fewer when fewer beats remain, so the final beat of the block is always marked last.
- R5: A pause moves an active channel to paused (status 2), and no `wr_valid` is raised while paused. A pause in the idle state is ignored.
- R6: A restart moves a paused channel back to active. The fill continues at the next unwritten address, with no beat lost or repeated. A restart in the idle or active state is ignored.
- R7: A stop moves an active channel to idle at once and ends the fill. In the idle state a stop has no effect, and a paused channel ignores it. If stop and pause are both set in one write, stop wins.
- R8: A start while active or paused is ignored, and the fill in progress keeps its addresses.
- R9: The channel refuses a start and stays idle when any of these holds: the mode is not 2, SIZE is below 8, SIZE is above 0x0100_0000, or SIZE is not a multiple of 8.
- R10: A write to CFG updates only the burst limit fields and leaves the mode unchanged. Only a write to MODE changes the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wr_valid | output | 1 | Write beat request |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | 32 | Beat byte address |
| wr_data | output | 64 | Beat data |
| wr_last | output | 1 | Final beat of a burst |

## Verification
The assertions check several properties on every cycle: the status is always one of the three legal codes, and writes are requested only while the channel is active. They also check that accepted beats step the address by 8, that a write to CFG never moves the mode, and that idle-to-active and paused-to-active moves happen only after a start or restart write. The total beat count, burst framing, pattern contents, refusal of bad sizes and modes, and resumption after a pause at the right address come from the bench scenarios. Those scenarios compare the captured beats against values computed from the programmed registers.

// File: rtl/memfill_pkg.sv
package memfill_pkg;

    localparam int REG_AW   = 3;
    localparam int REG_DW   = 32;
    localparam int BL_W     = 4;
    localparam int BL_RESET = 4;
    localparam int BEAT_B   = 8;

    localparam logic [REG_AW-1:0] RA_CFG   = 3'd0;
    localparam logic [REG_AW-1:0] RA_MODE  = 3'd1;
    localparam logic [REG_AW-1:0] RA_DST   = 3'd2;
    localparam logic [REG_AW-1:0] RA_SIZE  = 3'd3;
    localparam logic [REG_AW-1:0] RA_PATLO = 3'd4;
    localparam logic [REG_AW-1:0] RA_PATHI = 3'd5;
    localparam logic [REG_AW-1:0] RA_ACT   = 3'd6;

    localparam logic [2:0] MODE_FILL = 3'd2;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'b00,
        CH_ACTIVE = 2'b01,
        CH_PAUSED = 2'b10
    } chan_state_e;

    typedef struct packed {
        logic resume;
        logic pause;
        logic stop;
        logic start;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [3:0] bits);
        cmd_t c;
        c.start  = bits[0];
        c.stop   = bits[1];
        c.pause  = bits[2];
        c.resume = bits[3];
        return c;
    endfunction

endpackage

// File: rtl/memfill_regs.sv
module memfill_regs
    import memfill_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  chan_state_e       state,
    output logic [REG_DW-1:0] rdata,
    output logic [2:0]        opmode,
    output logic [BL_W-1:0]   dst_lim,
    output logic [AW-1:0]     dst_ptr,
    output logic [SZW-1:0]    blk_size,
    output logic [63:0]       pattern,
    output cmd_t              cmd
);
    logic [BL_W-1:0] src_lim;
    logic [31:0]     pat_lo, pat_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            opmode   <= '0;
            dst_lim  <= BL_W'(BL_RESET);
            src_lim  <= BL_W'(BL_RESET);
            dst_ptr  <= '0;
            blk_size <= '0;
            pat_lo   <= '0;
            pat_hi   <= '0;
        end else if (we) begin
            case (addr)
                RA_CFG: begin
                    dst_lim <= wdata[8 +: BL_W];
                    src_lim <= wdata[12 +: BL_W];
                end
                RA_MODE:  opmode   <= wdata[2:0];
                RA_DST:   dst_ptr  <= wdata[AW-1:0];
                RA_SIZE:  blk_size <= wdata[SZW-1:0];
                RA_PATLO: pat_lo   <= wdata;
                RA_PATHI: pat_hi   <= wdata;
                default: ;
            endcase
        end
    end

    assign pattern = {pat_hi, pat_lo};
    assign cmd     = (we && addr == RA_ACT) ? decode_cmd(wdata[3:0]) : '0;

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CFG: begin
                rdata[2:0]       = opmode;
                rdata[8 +: BL_W] = dst_lim;
                rdata[12 +: BL_W] = src_lim;
            end
            RA_MODE:  rdata[2:0]     = opmode;
            RA_DST:   rdata[AW-1:0]  = dst_ptr;
            RA_SIZE:  rdata[SZW-1:0] = blk_size;
            RA_PATLO: rdata = pat_lo;
            RA_PATHI: rdata = pat_hi;
            RA_ACT:   rdata[1:0] = state;
            default: ;
        endcase
    end
endmodule

// File: rtl/memfill_ctrl.sv
module memfill_ctrl
    import memfill_pkg::*;
#(
    parameter int          SZW     = 32,
    parameter logic [31:0] BLK_MIN = 32'd8,
    parameter logic [31:0] BLK_MAX = 32'h0100_0000
) (
    input  logic           clk,
    input  logic           rst,
    input  cmd_t           cmd,
    input  logic [2:0]     opmode,
    input  logic [SZW-1:0] blk_size,
    input  logic           done,
    output chan_state_e    state,
    output logic           launch,
    output logic           abort
);
    localparam logic [SZW-1:0] MIN_S = SZW'(BLK_MIN);
    localparam logic [SZW-1:0] MAX_S = SZW'(BLK_MAX);

    chan_state_e state_d;
    logic        size_ok;

    assign size_ok = (opmode == MODE_FILL) && (blk_size >= MIN_S) &&
                     (blk_size <= MAX_S) && (blk_size[2:0] == 3'b000);

    always_comb begin
        state_d = state;
        launch  = 1'b0;
        abort   = 1'b0;
        case (state)
            CH_IDLE: if (cmd.start && size_ok) begin
                state_d = CH_ACTIVE;
                launch  = 1'b1;
            end
            CH_ACTIVE: begin
                if (done) begin
                    state_d = CH_IDLE;
                end else if (cmd.stop) begin
                    state_d = CH_IDLE;
                    abort   = 1'b1;
                end else if (cmd.pause) begin
                    state_d = CH_PAUSED;
                end
            end
            CH_PAUSED: if (cmd.resume) state_d = CH_ACTIVE;
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CH_IDLE;
        else     state <= state_d;
    end
endmodule

// File: rtl/memfill_beat.sv
module memfill_beat
    import memfill_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             abort,
    input  logic             run,
    input  logic [AW-4:0]    start_word,
    input  logic [SZW-4:0]   beats_req,
    input  logic [BL_W-1:0]  dst_lim,
    input  logic [63:0]      pattern,
    input  logic             wr_ready,
    output logic             wr_valid,
    output logic [AW-1:0]    wr_addr,
    output logic [63:0]      wr_data,
    output logic             wr_last,
    output logic             done
);
    localparam int BCW = SZW - 3;

    logic [AW-1:0]   cur_addr;
    logic [BCW-1:0]  beats_left;
    logic [BL_W-1:0] burst_rem;
    logic [BL_W-1:0] lim_eff, new_len;
    logic            accept;

    assign lim_eff = (dst_lim == '0) ? BL_W'(1) : dst_lim;
    assign new_len = (beats_left < BCW'(lim_eff)) ? beats_left[BL_W-1:0] : lim_eff;

    assign wr_valid = run && (beats_left != '0);
    assign accept   = wr_valid && wr_ready;
    assign done     = accept && (beats_left == BCW'(1));
    assign wr_addr  = cur_addr;
    assign wr_data  = pattern;
    assign wr_last  = (burst_rem == '0) ? (new_len == BL_W'(1)) : (burst_rem == BL_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr   <= '0;
            beats_left <= '0;
            burst_rem  <= '0;
        end else if (launch) begin
            cur_addr   <= {start_word, 3'b000};
            beats_left <= beats_req;
            burst_rem  <= '0;
        end else if (abort) begin
            beats_left <= '0;
            burst_rem  <= '0;
        end else if (accept) begin
            cur_addr   <= cur_addr + AW'(BEAT_B);
            beats_left <= beats_left - BCW'(1);
            burst_rem  <= (burst_rem == '0) ? new_len - BL_W'(1) : burst_rem - BL_W'(1);
        end
    end
endmodule

// File: rtl/memfill_chan.sv
module memfill_chan
    import memfill_pkg::*;
#(
    parameter int          AW      = 32,
    parameter int          SZW     = 32,
    parameter logic [31:0] BLK_MIN = 32'd8,
    parameter logic [31:0] BLK_MAX = 32'h0100_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        wr_valid,
    input  logic        wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [63:0] wr_data,
    output logic        wr_last
);
    chan_state_e     ch_state;
    cmd_t            cmd;
    logic [2:0]      cfg_mode;
    logic [BL_W-1:0] dst_lim;
    logic [AW-1:0]   dst_ptr;
    logic [SZW-1:0]  blk_size;
    logic [63:0]     pattern;
    logic            launch, abort, done;

    memfill_regs #(.AW(AW), .SZW(SZW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .state(ch_state), .rdata(reg_rdata),
        .opmode(cfg_mode), .dst_lim(dst_lim), .dst_ptr(dst_ptr),
        .blk_size(blk_size), .pattern(pattern), .cmd(cmd)
    );

    memfill_ctrl #(.SZW(SZW), .BLK_MIN(BLK_MIN), .BLK_MAX(BLK_MAX)) u_ctrl (
        .clk(clk), .rst(rst), .cmd(cmd), .opmode(cfg_mode),
        .blk_size(blk_size), .done(done), .state(ch_state),
        .launch(launch), .abort(abort)
    );

    memfill_beat #(.AW(AW), .SZW(SZW)) u_beat (
        .clk(clk), .rst(rst), .launch(launch), .abort(abort),
        .run(ch_state == CH_ACTIVE), .start_word(dst_ptr[AW-1:3]),
        .beats_req(blk_size[SZW-1:3]), .dst_lim(dst_lim), .pattern(pattern),
        .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_last(wr_last), .done(done)
    );
endmodule

// File: rtl/memfill_chan_sva.sv
module memfill_chan_sva
    import memfill_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr_en,
    input logic [2:0]    reg_addr,
    input logic [3:0]    cmd_bits,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [1:0]    state,
    input logic [2:0]    opmode
);
    logic act_wr;
    assign act_wr = reg_wr_en && (reg_addr == RA_ACT);

    assert_status_legal_R1: assert property (@(posedge clk) disable iff (rst)
        state != 2'b11);

    assert_valid_when_active_R5: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> state == CH_ACTIVE);

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (!wr_valid || wr_addr == $past(wr_addr) + AW'(8)));

    assert_mode_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == RA_CFG) |=> $stable(opmode));

    assert_start_from_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (state == CH_ACTIVE && $past(state) == CH_IDLE) |-> $past(act_wr && cmd_bits[0]));

    assert_resume_from_pause_R6: assert property (@(posedge clk) disable iff (rst)
        (state == CH_ACTIVE && $past(state) == CH_PAUSED) |-> $past(act_wr && cmd_bits[3]));

    assert_pause_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (state == CH_PAUSED && $past(state) == CH_PAUSED) |-> $stable(wr_addr));
endmodule

bind memfill_chan memfill_chan_sva #(.AW(AW)) u_sva (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .cmd_bits(reg_wdata[3:0]), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .state(ch_state), .opmode(cfg_mode)
);

// File: tb/memfill_chan_tb.sv
module memfill_chan_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wr_valid, wr_last;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;

    logic rdy_toggle = 1'b0;
    logic rdy_level  = 1'b1;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mon_addr [0:63];
    logic [63:0] mon_data [0:63];
    logic        mon_last [0:63];
    int          mon_n = 0;
    logic        mon_clr = 1'b0;

    localparam logic [63:0] PAT = 64'hA5C3_0F1E_7B2D_9600;

    memfill_chan u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        #2;
        wr_ready <= rdy_toggle ? ~wr_ready : rdy_level;
    end

    always @(negedge clk) begin
        if (mon_clr) begin
            mon_n = 0;
        end else if (wr_valid && wr_ready) begin
            if (mon_n < 64) begin
                mon_addr[mon_n] = wr_addr;
                mon_data[mon_n] = wr_data;
                mon_last[mon_n] = wr_last;
            end
            mon_n = mon_n + 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic status(output logic [1:0] s);
        logic [31:0] d;
        rd_reg(3'd6, d);
        s = d[1:0];
    endtask

    task automatic clear_mon();
        @(posedge clk); #1 mon_clr = 1'b1;
        @(negedge clk); #1 mon_clr = 1'b0;
    endtask

    task automatic wait_idle();
        logic [1:0] s;
        for (int i = 0; i < 5000; i++) begin
            status(s);
            if (s == 2'd0) break;
        end
    endtask

    task automatic setup(input logic [31:0] dst, input logic [31:0] size, input logic [3:0] lim);
        wr_reg(3'd0, {16'h0, 4'd4, lim, 8'h0});
        wr_reg(3'd1, 32'd2);
        wr_reg(3'd2, dst);
        wr_reg(3'd3, size);
        wr_reg(3'd4, PAT[31:0]);
        wr_reg(3'd5, PAT[63:32]);
    endtask

    task automatic check_run(input string req, input logic [31:0] base, input int n, input int lim);
        int ba = 0, bd = 0, bl = 0;
        chk(req, "beat count", 64'(mon_n), 64'(n));
        for (int i = 0; i < n && i < 64; i++) begin
            logic exp_last;
            exp_last = ((i + 1) % lim == 0) || (i == n - 1);
            if (mon_addr[i] !== base + 32'(8 * i)) ba++;
            if (mon_data[i] !== PAT) bd++;
            if (mon_last[i] !== exp_last) bl++;
        end
        chk(req, "address mismatches", 64'(ba), 64'd0);
        chk(req, "data mismatches", 64'(bd), 64'd0);
        chk(req, "last flag mismatches (R4)", 64'(bl), 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [1:0] s;
        status(s);
        chk("R1", "status after reset", 64'(s), 64'd0);
        rd_reg(3'd0, d);
        chk("R1", "cfg after reset", 64'(d), 64'h0000_4400);
        chk("R1", "wr_valid after reset", 64'(wr_valid), 64'd0);
    endtask

    task automatic t_fill();
        logic [1:0] s;
        rdy_toggle = 1'b0; rdy_level = 1'b1;
        setup(32'h0000_1000, 32'd80, 4'd4);
        clear_mon();
        wr_reg(3'd6, 32'h1);
        status(s);
        chk("R2", "status after start", 64'(s), 64'd1);
        wait_idle();
        repeat (5) @(posedge clk);
        check_run("R2 R3 R4", 32'h0000_1000, 10, 4);
        chk("R3", "wr_valid after done", 64'(wr_valid), 64'd0);
    endtask

    task automatic t_backpressure();
        logic [31:0] d;
        rdy_toggle = 1'b1;
        setup(32'h0000_2000, 32'd56, 4'd4);
        wr_reg(3'd0, 32'h0000_4300);
        rd_reg(3'd0, d);
        chk("R10", "mode kept over cfg write", 64'(d[2:0]), 64'd2);
        chk("R10", "burst limit written", 64'(d[11:8]), 64'd3);
        clear_mon();
        wr_reg(3'd6, 32'h1);
        wait_idle();
        check_run("R3 R4", 32'h0000_2000, 7, 3);
        rdy_toggle = 1'b0;
    endtask

    task automatic t_pause();
        logic [1:0] s;
        int n0;
        rdy_level = 1'b1;
        setup(32'h0000_3000, 32'd128, 4'd4);
        clear_mon();
        wr_reg(3'd6, 32'h1);
        repeat (3) @(posedge clk);
        wr_reg(3'd6, 32'h4);
        status(s);
        chk("R5", "status after pause", 64'(s), 64'd2);
        n0 = mon_n;
        repeat (8) @(posedge clk);
        chk("R5", "no beats while paused", 64'(mon_n), 64'(n0));
        chk("R5", "wr_valid low while paused", 64'(wr_valid), 64'd0);
        wr_reg(3'd6, 32'h1);
        wr_reg(3'd6, 32'h2);
        repeat (4) @(posedge clk);
        status(s);
        chk("R7 R8", "start and stop ignored while paused", 64'(s), 64'd2);
        chk("R8", "no beats after ignored start", 64'(mon_n), 64'(n0));
        wr_reg(3'd6, 32'h8);
        wait_idle();
        check_run("R6", 32'h0000_3000, 16, 4);
    endtask

    task automatic t_idle_cmds();
        logic [1:0] s;
        clear_mon();
        wr_reg(3'd6, 32'h4);
        status(s);
        chk("R5", "pause while idle", 64'(s), 64'd0);
        wr_reg(3'd6, 32'h8);
        status(s);
        chk("R6", "restart while idle", 64'(s), 64'd0);
        wr_reg(3'd6, 32'h2);
        status(s);
        chk("R7", "stop while idle", 64'(s), 64'd0);
        chk("R7", "no beats from idle commands", 64'(mon_n), 64'd0);
    endtask

    task automatic t_refuse();
        logic [1:0] s;
        logic [31:0] d;
        clear_mon();
        setup(32'h0000_4000, 32'd0, 4'd4);
        wr_reg(3'd6, 32'h1);
        status(s);
        chk("R9", "size zero refused", 64'(s), 64'd0);
        wr_reg(3'd3, 32'h0100_0008);
        wr_reg(3'd6, 32'h1);
        status(s);
        chk("R9", "size above max refused", 64'(s), 64'd0);
        wr_reg(3'd3, 32'd20);
        wr_reg(3'd6, 32'h1);
        status(s);
        chk("R9", "unaligned size refused", 64'(s), 64'd0);
        wr_reg(3'd3, 32'd16);
        wr_reg(3'd1, 32'd0);
        rd_reg(3'd0, d);
        chk("R10", "mode write path", 64'(d[2:0]), 64'd0);
        wr_reg(3'd6, 32'h1);
        status(s);
        chk("R9", "wrong mode refused", 64'(s), 64'd0);
        repeat (3) @(posedge clk);
        chk("R9", "no beats from refused starts", 64'(mon_n), 64'd0);
        wr_reg(3'd1, 32'd2);
        clear_mon();
        wr_reg(3'd3, 32'd8);
        wr_reg(3'd6, 32'h1);
        wait_idle();
        check_run("R9 min size", 32'h0000_4000, 1, 4);
    endtask

    task automatic t_stop();
        logic [1:0] s;
        int n0;
        rdy_toggle = 1'b1;
        setup(32'h0000_5000, 32'd256, 4'd4);
        clear_mon();
        wr_reg(3'd6, 32'h1);
        repeat (4) @(posedge clk);
        wr_reg(3'd6, 32'h6);
        status(s);
        chk("R7", "stop wins over pause", 64'(s), 64'd0);
        n0 = mon_n;
        repeat (6) @(posedge clk);
        chk("R7", "no beats after stop", 64'(mon_n), 64'(n0));
        chk("R7", "stop cut the fill short", 64'(n0 < 32), 64'd1);
        clear_mon();
        wr_reg(3'd3, 32'd96);
        wr_reg(3'd6, 32'h1);
        repeat (3) @(posedge clk);
        wr_reg(3'd6, 32'h1);
        wr_reg(3'd6, 32'h8);
        status(s);
        chk("R6 R8", "start and restart ignored while active", 64'(s), 64'd1);
        wait_idle();
        check_run("R8", 32'h0000_5000, 12, 4);
        rdy_toggle = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        t_fill();
        t_backpressure();
        t_pause();
        t_idle_cmds();
        t_refuse();
        t_stop();
        repeat (5) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule